// File: doc/BRIEF.md
# Adaptive Suspect Bisection Controller

This block runs the diagnosis that follows a failed tile self-test. When `start` is pulsed, every cell in `tile_mask` becomes a suspect. The controller splits a failing group into two subsets along row boundaries and asks an external test agent to test each subset. It uses the pass/fail answers to discard subsets that are clean and to split again the subsets that still fail. The test agent does the reconfiguration and the test runs; the controller only talks to it through a request/response port.

A group narrowed to one cell is recorded in `fault_mask`. A group whose members all sit in one row cannot be split into separate vertical test groups. Such a group is recorded in `handoff_mask`, so that the row can be retested in the horizontal orientation. If a group failed as a whole but both of its halves then pass, all of that group's cells are marked faulty together. When no group is left to examine, `done` rises and both masks hold steady until the next start.

Cells are numbered from 0 to N_CELLS-1. Cell i lies in row i / ROW_CELLS.

Top module: `suspect_bisect`

## Requirements
- R1: A `start` accepted while `busy` is low clears `done`, `fault_mask` and `handoff_mask`, raises `busy` one cycle later, and makes every cell set in `tile_mask` a suspect.
- R2: To split a group that occupies r rows (r at least 2), subset A takes the cells of the group in its floor(r/2) lowest-numbered occupied rows. Subset B takes the rest of the group. A is requested first and B second.
- R3: Once `req_valid` is high, it and `req_mask` stay unchanged until a cycle with `rsp_valid` high. A `rsp_valid` pulse while no request is outstanding has no effect.
- R4: A subset answered with `rsp_pass`=1 is never requested again. The failed subsets are examined depth first: a failed A, with everything split from it, is finished before a failed B of the same split.
- R5: A failing group that holds a single cell is set in `fault_mask` without issuing any request.
- R6: If both subsets of a split pass, every cell of the parent group is set in `fault_mask`.
- R7: A group with two or more cells that all sit in one row is set in `handoff_mask` and produces no request. `fault_mask` and `handoff_mask` never share a cell.
- R8: Once no group is left, `done` rises, `busy` falls, and `done`, `fault_mask` and `handoff_mask` hold until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored: the requests and the results are the same as without it.
- R10: A start with an all-zero `tile_mask` raises `done` with both masks zero and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin diagnosis of `tile_mask` |
| tile_mask | input | N_CELLS | Cells of the tile that failed self-test |
| req_valid | output | 1 | A subset test is requested |
| req_mask | output | N_CELLS | Cells of the subset to test |
| rsp_valid | input | 1 | The test result is present this cycle |
| rsp_pass | input | 1 | 1 when the subset passed |
| busy | output | 1 | Diagnosis in progress |
| done | output | 1 | Diagnosis finished and results valid |
| fault_mask | output | N_CELLS | Cells confirmed faulty |
| handoff_mask | output | N_CELLS | Cells that need a retest in the other orientation |

## Verification
A single fault in a full tile drives the search to a row pair that must be handed off. A single fault in a tile of three rows shows the uneven two-and-four split. Two faults in different rows end as individual confirmed cells, and a set of faults on alternating cells exercises the depth-first order over several stacked groups. A fault-free response set, where the parent failed but both halves pass, marks the group faulty as a whole. Single-cell, single-row and empty tiles reach their results without any request. Varied response latency, a stray start during a run and a stray response while idle show that requests are held and that spurious inputs change nothing.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_POP   = 2'd1,
      ST_REQ_A = 2'd2,
      ST_REQ_B = 2'd3
   } bsc_state_e;

   function automatic int bsc_rows(input int cells, input int per_row);
      return cells / per_row;
   endfunction

endpackage

// File: rtl/bsc_split.sv
module bsc_split #(
   parameter int N    = 8,
   parameter int COLS = 2
) (
   input  logic [N-1:0]             group_i,
   output logic [N-1:0]             sub_a_o,
   output logic [N-1:0]             sub_b_o,
   output logic [$clog2(N+1)-1:0]   cells_o,
   output logic [$clog2(N+1)-1:0]   rows_o
);
   localparam int NROW = bsc_pkg::bsc_rows(N, COLS);

   logic [NROW-1:0] occ;

   generate
      if (COLS == 1) begin : g_flat
         assign occ = group_i;
      end else begin : g_rows
         for (genvar r = 0; r < NROW; r++) begin : g_r
            assign occ[r] = |group_i[r*COLS +: COLS];
         end
      end
   endgenerate

   always_comb begin
      cells_o = '0;
      for (int i = 0; i < N; i++) begin
         if (group_i[i]) cells_o = cells_o + 1'b1;
      end
   end

   always_comb begin
      rows_o = '0;
      for (int r = 0; r < NROW; r++) begin
         if (occ[r]) rows_o = rows_o + 1'b1;
      end
   end

   // lower half of the occupied rows (rounded down) forms subset A
   always_comb begin
      int half;
      int taken;
      half    = int'(rows_o) / 2;
      taken   = 0;
      sub_a_o = '0;
      for (int r = 0; r < NROW; r++) begin
         if (occ[r]) begin
            if (taken < half) sub_a_o[r*COLS +: COLS] = group_i[r*COLS +: COLS];
            taken = taken + 1;
         end
      end
      sub_b_o = group_i & ~sub_a_o;
   end

endmodule

// File: rtl/bsc_stack.sv
module bsc_stack #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear_i,
   input  logic                       pop_i,
   input  logic                       push_lo_en_i,
   input  logic [W-1:0]               push_lo_i,
   input  logic                       push_hi_en_i,
   input  logic [W-1:0]               push_hi_i,
   output logic [W-1:0]               top_o,
   output logic                       empty_o,
   output logic [$clog2(DEPTH+1)-1:0] level_o
);
   localparam int LW = $clog2(DEPTH+1);

   logic [W-1:0]  mem [DEPTH];
   logic [LW-1:0] lvl;
   logic [LW-1:0] base;
   int            hi_slot;

   assign base    = clear_i ? '0 : lvl;
   assign hi_slot = int'(base) + (push_lo_en_i ? 1 : 0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl <= '0;
      end else if (pop_i) begin
         lvl <= base - 1'b1;
      end else begin
         lvl <= base + LW'(push_lo_en_i) + LW'(push_hi_en_i);
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push_lo_en_i && i == int'(base)) mem[i] <= push_lo_i;
         if (push_hi_en_i && i == hi_slot)    mem[i] <= push_hi_i;
      end
   end

   always_comb begin
      top_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (i == int'(lvl) - 1) top_o = mem[i];
      end
   end

   assign empty_o = (lvl == '0);
   assign level_o = lvl;

endmodule

// File: rtl/suspect_bisect.sv
module suspect_bisect
   import bsc_pkg::*;
#(
   parameter int N_CELLS   = 8,
   parameter int ROW_CELLS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [N_CELLS-1:0] tile_mask,
   output logic               req_valid,
   output logic [N_CELLS-1:0] req_mask,
   input  logic               rsp_valid,
   input  logic               rsp_pass,
   output logic               busy,
   output logic               done,
   output logic [N_CELLS-1:0] fault_mask,
   output logic [N_CELLS-1:0] handoff_mask
);
   localparam int CW = $clog2(N_CELLS+1);

   generate
      if (N_CELLS < 2) begin : g_bad_cells
         $error("suspect_bisect: N_CELLS must be at least 2");
      end
      if (ROW_CELLS < 1 || (N_CELLS % ROW_CELLS) != 0) begin : g_bad_rows
         $error("suspect_bisect: ROW_CELLS must divide N_CELLS");
      end
   endgenerate

   bsc_state_e         state;
   logic [N_CELLS-1:0] grp_top;
   logic               stk_empty;
   logic [CW-1:0]      stk_lvl;
   logic [N_CELLS-1:0] split_a;
   logic [N_CELLS-1:0] split_b;
   logic [CW-1:0]      grp_cells;
   logic [CW-1:0]      grp_rows;

   logic [N_CELLS-1:0] sub_a_q;
   logic [N_CELLS-1:0] sub_b_q;
   logic [N_CELLS-1:0] parent_q;
   logic               a_fail_q;
   logic [N_CELLS-1:0] fault_q;
   logic [N_CELLS-1:0] hand_q;
   logic               done_q;

   logic               stk_clear;
   logic               stk_pop;
   logic               push_lo_en;
   logic [N_CELLS-1:0] push_lo;
   logic               push_hi_en;
   logic               rsp_b;

   assign stk_clear  = (state == ST_IDLE) && start;
   assign rsp_b      = (state == ST_REQ_B) && rsp_valid;
   assign push_lo_en = stk_clear ? (tile_mask != '0) : (rsp_b && !rsp_pass);
   assign push_lo    = stk_clear ? tile_mask : sub_b_q;
   assign push_hi_en = rsp_b && a_fail_q;
   assign stk_pop    = (state == ST_POP) && !stk_empty;

   bsc_stack #(.W(N_CELLS), .DEPTH(N_CELLS)) u_stack (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (stk_clear),
      .pop_i        (stk_pop),
      .push_lo_en_i (push_lo_en),
      .push_lo_i    (push_lo),
      .push_hi_en_i (push_hi_en),
      .push_hi_i    (sub_a_q),
      .top_o        (grp_top),
      .empty_o      (stk_empty),
      .level_o      (stk_lvl)
   );

   bsc_split #(.N(N_CELLS), .COLS(ROW_CELLS)) u_split (
      .group_i (grp_top),
      .sub_a_o (split_a),
      .sub_b_o (split_b),
      .cells_o (grp_cells),
      .rows_o  (grp_rows)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sub_a_q  <= '0;
         sub_b_q  <= '0;
         parent_q <= '0;
         a_fail_q <= 1'b0;
         fault_q  <= '0;
         hand_q   <= '0;
         done_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  fault_q <= '0;
                  hand_q  <= '0;
                  done_q  <= 1'b0;
                  state   <= ST_POP;
               end
            end
            ST_POP: begin
               if (stk_empty) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else if (grp_cells == CW'(1)) begin
                  fault_q <= fault_q | grp_top;
               end else if (grp_rows <= CW'(1)) begin
                  hand_q <= hand_q | grp_top;
               end else begin
                  sub_a_q  <= split_a;
                  sub_b_q  <= split_b;
                  parent_q <= grp_top;
                  state    <= ST_REQ_A;
               end
            end
            ST_REQ_A: begin
               if (rsp_valid) begin
                  a_fail_q <= !rsp_pass;
                  state    <= ST_REQ_B;
               end
            end
            default: begin
               if (rsp_valid) begin
                  if (!a_fail_q && rsp_pass) fault_q <= fault_q | parent_q;
                  state <= ST_POP;
               end
            end
         endcase
      end
   end

   assign req_valid    = (state == ST_REQ_A) || (state == ST_REQ_B);
   assign req_mask     = (state == ST_REQ_A) ? sub_a_q :
                         (state == ST_REQ_B) ? sub_b_q : '0;
   assign busy         = (state != ST_IDLE);
   assign done         = done_q;
   assign fault_mask   = fault_q;
   assign handoff_mask = hand_q;

endmodule

// File: rtl/suspect_bisect_chk.sv
module suspect_bisect_chk #(
   parameter int N_CELLS = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         start,
   input logic [N_CELLS-1:0]           tile_mask,
   input logic                         req_valid,
   input logic [N_CELLS-1:0]           req_mask,
   input logic                         rsp_valid,
   input logic                         busy,
   input logic                         done,
   input logic [N_CELLS-1:0]           fault_mask,
   input logic [N_CELLS-1:0]           handoff_mask,
   input logic [$clog2(N_CELLS+1)-1:0] stack_level
);
   logic [N_CELLS-1:0] tile_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tile_q <= '0;
      else if (start && !busy)   tile_q <= tile_mask;
   end

   // R1
   a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy && !done);

   // R2
   a_r2_req_in_tile: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_mask != '0) && ((req_mask & ~tile_q) == '0));

   // R3
   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !rsp_valid |=> req_valid && $stable(req_mask));

   // R4
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(stack_level) <= N_CELLS);

   // R7
   a_r7_masks_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((fault_mask & handoff_mask) == '0) &&
               (((fault_mask | handoff_mask) & ~tile_q) == '0));

   // R8
   a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done && $stable(fault_mask) && $stable(handoff_mask));

   // R8
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done) && !(done && req_valid));

endmodule

bind suspect_bisect suspect_bisect_chk #(.N_CELLS(N_CELLS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .tile_mask    (tile_mask),
   .req_valid    (req_valid),
   .req_mask     (req_mask),
   .rsp_valid    (rsp_valid),
   .busy         (busy),
   .done         (done),
   .fault_mask   (fault_mask),
   .handoff_mask (handoff_mask),
   .stack_level  (stk_lvl)
);

// File: tb/suspect_bisect_bench.sv
`timescale 1ns/1ps
module suspect_bisect_bench;
   localparam int NC = 8;
   localparam int RC = 2;
   localparam int NR = NC / RC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NC-1:0] tile_mask = '0;
   logic          req_valid;
   logic [NC-1:0] req_mask;
   logic          rsp_valid = 1'b0;
   logic          rsp_pass = 1'b0;
   logic          busy;
   logic          done;
   logic [NC-1:0] fault_mask;
   logic [NC-1:0] handoff_mask;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   logic [NC-1:0] exp_reqs[$];
   logic [NC-1:0] exp_fault;
   logic [NC-1:0] exp_hand;

   suspect_bisect #(.N_CELLS(NC), .ROW_CELLS(RC)) u_suspect_bisect (
      .clk(clk), .rst_n(rst_n), .start(start), .tile_mask(tile_mask),
      .req_valid(req_valid), .req_mask(req_mask),
      .rsp_valid(rsp_valid), .rsp_pass(rsp_pass),
      .busy(busy), .done(done),
      .fault_mask(fault_mask), .handoff_mask(handoff_mask));

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish, act cycles=%0d exp below 100000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [NC-1:0] act,
                      input logic [NC-1:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // behavioural reference: worklist of failing groups, depth first
   task automatic build_model(input logic [NC-1:0] tile, input logic [NC-1:0] flt);
      logic [NC-1:0] work[$];
      int            rows[$];
      logic [NC-1:0] g;
      logic [NC-1:0] a;
      logic [NC-1:0] b;
      bit            pa;
      bit            pb;
      bit            any;
      exp_reqs.delete();
      exp_fault = '0;
      exp_hand  = '0;
      if (tile != '0) work.push_back(tile);
      while (work.size() > 0) begin
         g = work.pop_front();
         rows.delete();
         for (int r = 0; r < NR; r++) begin
            any = 0;
            for (int c = 0; c < RC; c++) if (g[r*RC+c]) any = 1;
            if (any) rows.push_back(r);
         end
         if ($countones(g) == 1) begin
            exp_fault = exp_fault | g;
         end else if (rows.size() == 1) begin
            exp_hand = exp_hand | g;
         end else begin
            a = '0;
            for (int k = 0; k < rows.size() / 2; k++)
               for (int c = 0; c < RC; c++) a[rows[k]*RC+c] = g[rows[k]*RC+c];
            b = g & ~a;
            exp_reqs.push_back(a);
            exp_reqs.push_back(b);
            pa = ((a & flt) == '0);
            pb = ((b & flt) == '0);
            if (pa && pb) exp_fault = exp_fault | g;
            else begin
               if (!pb) work.push_front(b);
               if (!pa) work.push_front(a);
            end
         end
      end
   endtask

   task automatic run_case(input logic [NC-1:0] tile, input logic [NC-1:0] flt,
                           input int lat, input bit junk, input string tag);
      int idx;
      int wcnt;
      int guard;
      logic [NC-1:0] e;
      build_model(tile, flt);
      @(negedge clk);
      start = 1'b1;
      tile_mask = tile;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1 && done == 1'b0, {"R1 busy after start ", tag}, {6'b0, busy, done}, 8'h02);
      chk(fault_mask == '0 && handoff_mask == '0, {"R1 masks cleared ", tag},
          fault_mask | handoff_mask, 8'h00);
      idx = 0; wcnt = 0; guard = 0;
      while (!done && guard < 2000) begin
         start = junk && (guard == 4);
         tile_mask = (junk && guard == 4) ? 8'hFF : tile;
         if (rsp_valid) begin
            rsp_valid = 1'b0;
         end else if (req_valid) begin
            e = (idx < exp_reqs.size()) ? exp_reqs[idx] : 8'h00;
            chk(idx < exp_reqs.size() && req_mask == e,
                {"R2 R3 R4 request order/hold ", tag}, req_mask, e);
            if (wcnt >= lat) begin
               rsp_valid = 1'b1;
               rsp_pass  = ((req_mask & flt) == '0);
               idx = idx + 1;
               wcnt = 0;
            end else begin
               wcnt = wcnt + 1;
            end
         end
         @(negedge clk);
         guard = guard + 1;
      end
      start = 1'b0;
      rsp_valid = 1'b0;
      chk(done == 1'b1 && busy == 1'b0, {"R8 done and idle ", tag}, {6'b0, done, busy}, 8'h02);
      chk(idx == exp_reqs.size(), {"R2 request count ", tag}, idx[NC-1:0], exp_reqs.size());
      chk(fault_mask == exp_fault, {"R5 R6 fault mask ", tag}, fault_mask, exp_fault);
      chk(handoff_mask == exp_hand, {"R7 handoff mask ", tag}, handoff_mask, exp_hand);
      repeat (3) @(negedge clk);
      chk(done == 1'b1 && fault_mask == exp_fault && handoff_mask == exp_hand,
          {"R8 results held ", tag}, fault_mask, exp_fault);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && req_valid == 0, "R1 reset state ctl",
          {5'b0, busy, done, req_valid}, 8'h00);
      chk(fault_mask == '0 && handoff_mask == '0, "R1 reset state masks",
          fault_mask | handoff_mask, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      run_case(8'hFF, 8'h04, 0, 0, "full tile one fault");
      run_case(8'h3F, 8'h10, 2, 0, "six cells uneven split");
      run_case(8'h05, 8'h05, 1, 0, "two faults separate rows");
      run_case(8'hFF, 8'h00, 0, 0, "R6 both halves pass");
      run_case(8'hAA, 8'h88, 3, 1, "R9 stray start alternating cells");
      run_case(8'h01, 8'h01, 0, 0, "R5 single cell");
      run_case(8'h30, 8'h10, 0, 0, "R7 single row");
      run_case(8'h00, 8'h00, 0, 0, "R10 empty tile");
      run_case(8'hFF, 8'hFF, 1, 0, "all faulty");

      // R3 stray response while idle changes nothing
      rsp_valid = 1'b1; rsp_pass = 1'b0;
      @(negedge clk);
      rsp_valid = 1'b0;
      @(negedge clk);
      chk(req_valid == 0 && busy == 0 && done == 1, "R3 stray response idle",
          {5'b0, req_valid, busy, done}, 8'h01);
      chk(fault_mask == exp_fault && handoff_mask == exp_hand, "R3 stray response masks",
          fault_mask, exp_fault);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule